// File: doc/BRIEF.md
# Fractional Microsecond Timebase Counter

This block turns a reference clock whose frequency is not a whole multiple of 1 MHz into an exact one-microsecond tick. It then counts those ticks in a free-running up-counter. The rate is set as a ratio in a 16-bit configuration word. The word gives C, the number of reference clocks in one period, and T, the number of ticks in that same period. A Bresenham-style accumulator issues the ticks. On every reference clock it adds T, and whenever the running sum reaches C it issues a tick and subtracts C. The ticks are therefore spread as evenly as the clock grid allows, and the long-run rate never drifts. Example settings are 0x000B for 12 MHz (12 clocks per tick), 0x043F for 12.8 MHz (64 clocks per 5 ticks), 0x045F for 19.2 MHz and 0x04BF for 38.4 MHz.

A small register bus writes the configuration and reads back either the configuration or the live count. Reads are combinational and take effect in the same cycle. Writes take effect at the clock edge.

The rate generator is a two-state machine:
- **GEN_RESTART** clears the accumulator and issues no tick.
- **GEN_RUN** accumulates and issues ticks.

Its transitions are:
- **reset entry**: reset places the machine in GEN_RESTART.
- **restart done**: GEN_RESTART always moves to GEN_RUN after one cycle.
- **run hold**: GEN_RUN stays in GEN_RUN.
- **reconfigure**: a configuration write forces GEN_RESTART from either state.

Top module: `usec_timebase`

## Requirements
- R1: Address 0 holds the configuration word, returned on bus_rdata[15:0] with the upper bits zero. Bits [7:0] hold C-1 (reference clocks per period) and bits [15:8] hold T-1 (ticks per period). A write at address 0 takes bus_wdata[15:0].
- R2: When T < C, the counter advances by exactly floor(N*T/C) after N cycles in GEN_RUN counted from a restart. It never advances by more than one per cycle, and it changes only on a tick.
- R3: When T >= C, a tick is issued on every cycle in GEN_RUN.
- R4: A configuration write moves the generator to GEN_RESTART on the next cycle. That cycle issues no tick and clears the accumulator, so counting resumes from zero phase with the new ratio.
- R5: A configuration write leaves the counter value unchanged. A tick that the old ratio produces in the write cycle itself is still counted.
- R6: Address 1 returns the counter, zero-extended. Writes to address 1 and to the unused addresses 2 and 3 are ignored and do not restart the generator. Addresses 2 and 3 read as zero.
- R7: The counter wraps from its all-ones value to zero and raises no flag.
- R8: Reset loads configuration 0x000B and clears the counter and the accumulator. The first cycle after reset is a GEN_RESTART cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Register address (0 = config, 1 = counter) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Combinational read data |

## Verification
A configuration write and a tick from the old ratio can fall in the same cycle. When that happens, the tick must be counted while the accumulator restarts under the new ratio. The bench provokes this by chaining random-length run windows with random ratios, so that writes land at arbitrary accumulator phases. After each write it compares the count against the sum of the old window's ticks, taken over the window plus the write cycle itself. Writes to the counter address are likewise placed mid-window, and the bench judges them by confirming that the tick total still follows an unbroken floor(N*T/C).

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;

    typedef enum logic {
        GEN_RESTART = 1'b0,
        GEN_RUN     = 1'b1
    } gen_state_e;

    localparam logic [1:0] ADDR_CFG   = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;

endpackage

// File: rtl/usec_cfg_reg.sv
module usec_cfg_reg #(
    parameter int          FIELD_W   = 8,
    parameter int          CFG_W     = 2 * FIELD_W,
    parameter logic [CFG_W-1:0] RESET_CFG = CFG_W'(16'h000B)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CFG_W-1:0]   cfg,
    output logic [FIELD_W-1:0] clk_m1,
    output logic [FIELD_W-1:0] tick_m1
);
    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RESET_CFG;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end
    end

    assign cfg     = cfg_q;
    assign clk_m1  = cfg_q[FIELD_W-1:0];
    assign tick_m1 = cfg_q[CFG_W-1:FIELD_W];
endmodule

// File: rtl/usec_rate_gen.sv
module usec_rate_gen
    import usec_timebase_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_req,
    input  logic [FIELD_W-1:0] clk_m1,
    input  logic [FIELD_W-1:0] tick_m1,
    output logic               tick,
    output logic               in_restart
);
    localparam int SUM_W = FIELD_W + 1;

    gen_state_e       state_q, state_d;
    logic [SUM_W-1:0] acc_q, acc_d;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] clk_per;
    logic [SUM_W-1:0] tick_per;
    logic             saturate;

    assign clk_per  = {1'b0, clk_m1} + SUM_W'(1);
    assign tick_per = {1'b0, tick_m1} + SUM_W'(1);
    assign saturate = (tick_m1 >= clk_m1);
    assign sum      = acc_q + tick_per;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_RESTART;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_RESTART: state_d = GEN_RUN;
            GEN_RUN:     state_d = GEN_RUN;
        endcase
        if (restart_req) begin
            state_d = GEN_RESTART;
        end
    end

    // Outputs and accumulator
    always_comb begin
        tick  = 1'b0;
        acc_d = acc_q;
        unique case (state_q)
            GEN_RESTART: begin
                acc_d = '0;
            end
            GEN_RUN: begin
                if (saturate) begin
                    tick  = 1'b1;
                    acc_d = '0;
                end else if (sum >= clk_per) begin
                    tick  = 1'b1;
                    acc_d = sum - clk_per;
                end else begin
                    acc_d = sum;
                end
            end
        endcase
        if (restart_req) begin
            acc_d = '0;
        end
    end

    assign in_restart = (state_q == GEN_RESTART);
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_timebase_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2,
    localparam int CFG_W  = 2 * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CFG_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic               cfg_wr;
    logic [CFG_W-1:0]   cfg_val;
    logic [FIELD_W-1:0] clk_m1;
    logic [FIELD_W-1:0] tick_m1;
    logic               tick;
    logic               gen_restart;
    logic [CNT_W-1:0]   count_val;

    assign cfg_wr = bus_we && (bus_addr == ADDR_W'(ADDR_CFG));

    usec_cfg_reg #(
        .FIELD_W   (FIELD_W),
        .CFG_W     (CFG_W),
        .RESET_CFG (CFG_W'(16'h000B))
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (bus_wdata),
        .cfg     (cfg_val),
        .clk_m1  (clk_m1),
        .tick_m1 (tick_m1)
    );

    usec_rate_gen #(
        .FIELD_W (FIELD_W)
    ) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_req (cfg_wr),
        .clk_m1      (clk_m1),
        .tick_m1     (tick_m1),
        .tick        (tick),
        .in_restart  (gen_restart)
    );

    usec_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count_val)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CFG)) begin
            bus_rdata = DATA_W'(cfg_val);
        end else if (bus_addr == ADDR_W'(ADDR_COUNT)) begin
            bus_rdata = DATA_W'(count_val);
        end
    end
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             tick,
    input logic             in_restart,
    input logic [CNT_W-1:0] count
);
    // R4
    cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> in_restart);

    // R4
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_restart |-> !tick);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == CNT_W'($past(count) + CNT_W'(1))));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (count == {CNT_W{1'b1}})) |=> (count == '0));

    // R8
    reset_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> in_restart);
endmodule

bind usec_timebase usec_timebase_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .tick       (tick),
    .in_restart (gen_restart),
    .count      (count_val)
);

// File: tb/usec_timebase_tb.sv
`timescale 1ns/1ps
module usec_timebase_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd1;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    logic        s_we = 1'b0;
    logic [1:0]  s_addr = 2'd1;
    logic [15:0] s_wdata = '0;
    logic [31:0] s_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    usec_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    usec_timebase #(.CNT_W(8)) u_small (
        .clk(clk), .rst_n(rst_n), .bus_we(s_we), .bus_addr(s_addr),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata)
    );

    function automatic longint unsigned exp_ticks(longint unsigned n, logic [15:0] cfg);
        longint unsigned t = longint'(cfg[15:8]) + 1;
        longint unsigned c = longint'(cfg[7:0]) + 1;
        if (t >= c) return n;
        return (n * t) / c;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 2'd1;
    endtask

    // called in the low phase; returns in the low phase after edge E+1
    task automatic wr(logic [1:0] a, logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd1;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, base;
        logic [15:0] cur;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R8 reset values
        rd(2'd0, v); chk("R8 reset cfg", v, 32'h0000_000B);
        rd(2'd1, v); chk("R8 reset count", v, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);          // restart cycle
        rd(2'd1, base); chk("R8 restart cycle no tick", base, 32'h0);
        cur = 16'h000B;

        // R2 default 12 clocks per tick
        run(125); rd(2'd1, v); chk("R2 default ratio", v, base + 32'(exp_ticks(125, cur)));

        // R5: write edge counts old tick, then restart cycle
        wr(2'd0, 16'h043F);
        @(posedge clk); @(negedge clk);
        rd(2'd1, v); chk("R5 count kept over cfg write", v, base + 32'(exp_ticks(126, cur)));
        rd(2'd0, v); chk("R1 cfg readback", v, 32'h0000_043F);
        base = v; rd(2'd1, base); cur = 16'h043F;

        // R2 even spacing at 64 clocks per 5 ticks
        for (int k = 1; k <= 64; k++) begin
            run(1); rd(2'd1, v);
            chk($sformatf("R2 spacing k=%0d", k), v, base + 32'(exp_ticks(k, cur)));
        end
        run(576); rd(2'd1, v); chk("R2 640 clocks", v, base + 32'd50);

        // R6 writes to counter and unused addresses ignored
        wr(2'd0, 16'h045F); @(posedge clk); @(negedge clk);
        rd(2'd1, base); cur = 16'h045F;
        run(37); wr(2'd1, 16'hFFFF); run(20); wr(2'd2, 16'h1234); run(50);
        rd(2'd1, v); chk("R6 counter write ignored", v, base + 32'(exp_ticks(37 + 1 + 20 + 1 + 50, cur)));
        rd(2'd0, v); chk("R6 cfg unchanged", v, 32'h0000_045F);
        rd(2'd2, v); chk("R6 addr2 reads zero", v, 32'h0);
        rd(2'd3, v); chk("R6 addr3 reads zero", v, 32'h0);

        // R3 saturation
        wr(2'd0, 16'h0705); @(posedge clk); @(negedge clk);
        rd(2'd1, base); cur = 16'h0705;
        run(33); rd(2'd1, v); chk("R3 tick every cycle", v, base + 32'd33);

        // R4/R5 random chain of ratios with writes at random phases
        wr(2'd0, 16'h04BF); @(posedge clk); @(negedge clk);
        rd(2'd1, v); chk("R5 count kept after saturate", v, base + 32'd34);
        base = v; cur = 16'h04BF;
        for (int i = 0; i < 40; i++) begin
            int n = 1 + int'($urandom_range(600));
            logic [7:0] lo = 8'($urandom_range(255));
            logic [7:0] hi = (i % 5 == 4) ? 8'($urandom_range(255)) : 8'($urandom_range(int'(lo)));
            logic [15:0] nxt = {hi, lo};
            run(n); rd(2'd1, v);
            chk($sformatf("R2 window cfg=%04h n=%0d", cur, n), v, base + 32'(exp_ticks(n, cur)));
            wr(2'd0, nxt); @(posedge clk); @(negedge clk);
            rd(2'd1, v);
            chk($sformatf("R4 R5 rewrite to %04h", nxt), v, base + 32'(exp_ticks(n + 1, cur)));
            base = v; cur = nxt;
        end

        // R7 wrap on an 8-bit counter
        s_we = 1'b1; s_addr = 2'd0; s_wdata = 16'h0000;
        @(posedge clk); @(negedge clk);
        s_we = 1'b0; s_addr = 2'd1;
        @(posedge clk); @(negedge clk);
        #1 base = s_rdata;
        run(300);
        #1 chk("R7 wrap", s_rdata, (base + 32'd300) & 32'hFF);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule